// File: doc/BRIEF.md
# PCI Space Decoder and Command Encoder

This block sits between the address latch of a 32-bit multiplexed host expansion bus and the PCI master state machine of a host-to-PCI bridge. It is given a latched host address, a strobe that marks the address as valid, the read/write direction, and the window base that software programs at boot. From these it decides whether the access targets the bridge's 512 MB window. Inside the window, the offset selects one of four spaces: legacy I/O, PCI I/O, configuration and memory.

For an access that hits the window, the block produces the PCI command nibble for the address phase. It also produces the full address-phase AD value, including the two low bits. For configuration accesses it produces a one-hot slot select for four slots. Each slot has its own memory-mapped configuration region, so the slot and register number come straight from the host offset. No index and data register pair is involved. An optional output register stage, chosen by parameter, adds one cycle of latency.

Top module: `pci_space_decoder`

## Requirements
- R1: `hit_o` is 1 only when `addr_vld_i` is 1 and `addr_i[31:29]` equals `base_i`. When `hit_o` is 0, `space_o`, `cbe_o`, `ad_o` and `idsel_o` are all zero.
- R2: On a hit, `space_o` reports the space of the offset `addr_i[28:0]`. Offsets below 0x10000 give 0 (legacy I/O). Offsets from 0x10000 to 0xEFFFF give 1 (PCI I/O). Offsets from 0xF0000 to 0xFFFFF give 2 (configuration). Offsets from 0x100000 upward give 3 (memory).
- R3: A hit in memory space drives `cbe_o` = 0110 for a read (`we_i`=0) and 0111 for a write (`we_i`=1).
- R4: A hit in either I/O space (legacy or PCI) drives `cbe_o` = 0010 for a read and 0011 for a write. `idsel_o` stays 0.
- R5: A hit in configuration space drives `cbe_o` = 1010 for a read and 1011 for a write.
- R6: On a configuration hit, offset bits [9:8] select the slot. `idsel_o` is one-hot with bit n set for slot n. `ad_o[19:16]` equals `idsel_o`. `ad_o[7:2]` equals offset bits [7:2]. All other `ad_o` bits, including `ad_o[1:0]` (type 0), are 0.
- R7: On an I/O hit (legacy or PCI), `ad_o` equals offset bits [19:0] zero-extended. The low byte address bits therefore appear on `ad_o[1:0]`.
- R8: On a memory hit, `ad_o` equals the offset with `ad_o[1:0]` forced to 00 (linear burst order) and `ad_o[31:29]` = 0.
- R9: With the default registered output stage, outputs follow the inputs one clock later, and reset (`rst_ni`=0) clears all outputs to zero.
- R10: The range edges classify exactly: 0xFFFF→legacy, 0x10000 and 0xEFFFF→PCI I/O, 0xF0000 and 0xFFFFF→configuration, 0x100000 and 0x1FFFFFFF→memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_i | input | 3 | Window base, compared against address bits [31:29] |
| addr_vld_i | input | 1 | Latched address is valid |
| addr_i | input | 32 | Latched host address |
| we_i | input | 1 | 1 = write, 0 = read |
| hit_o | output | 1 | Access targets the bridge window |
| space_o | output | 2 | Decoded space: 0 legacy I/O, 1 PCI I/O, 2 config, 3 memory |
| cbe_o | output | 4 | PCI command for the address phase |
| ad_o | output | 32 | Address-phase AD value |
| idsel_o | output | 4 | One-hot slot select for configuration cycles |

## Verification
The bench hits every range edge on both sides, since an off-by-one compare would put 0xFFFF or 0xF0000 into the wrong space and issue the wrong command. It sweeps all four configuration slots with different register numbers; a shifted slot field would raise the wrong select line or leak offset bits into AD. It drives addresses that differ from the base in a single top bit, and addresses with the strobe low. A loose base compare would claim foreign accesses, and a missing zeroing path would leave a stale command on the bus. The bench also checks that a new input does not reach the outputs before the clock edge, and that I/O keeps its low byte bits while memory clears them.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;
  typedef enum logic [1:0] {
    SP_LEGACY = 2'd0,
    SP_IO     = 2'd1,
    SP_CFG    = 2'd2,
    SP_MEM    = 2'd3
  } space_e;

  // command codes, direction bit is the LSB
  localparam logic [2:0] CMD_IO  = 3'b001;
  localparam logic [2:0] CMD_MEM = 3'b011;
  localparam logic [2:0] CMD_CFG = 3'b101;
endpackage

// File: rtl/pci_window_match.sv
module pci_window_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WIN_W  = 29,
  localparam int unsigned BASE_W = ADDR_W - WIN_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              vld_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              hit_o,
  output logic [WIN_W-1:0]  offset_o
);
  assign hit_o    = vld_i && (addr_i[ADDR_W-1:WIN_W] == base_i);
  assign offset_o = addr_i[WIN_W-1:0];
endmodule

// File: rtl/pci_space_classify.sv
module pci_space_classify
  import pci_dec_pkg::*;
#(
  parameter int unsigned WIN_W     = 29,
  parameter int unsigned IO_START  = 32'h0001_0000,
  parameter int unsigned CFG_START = 32'h000F_0000,
  parameter int unsigned MEM_START = 32'h0010_0000
) (
  input  logic [WIN_W-1:0] offset_i,
  output space_e           space_o
);
  always_comb begin
    if (offset_i < WIN_W'(IO_START))       space_o = SP_LEGACY;
    else if (offset_i < WIN_W'(CFG_START)) space_o = SP_IO;
    else if (offset_i < WIN_W'(MEM_START)) space_o = SP_CFG;
    else                                   space_o = SP_MEM;
  end
endmodule

// File: rtl/pci_cmd_encode.sv
module pci_cmd_encode
  import pci_dec_pkg::*;
#(
  parameter int unsigned WIN_W     = 29,
  parameter int unsigned AD_W      = 32,
  parameter int unsigned SLOTS     = 4,
  parameter int unsigned IDSEL_LSB = 16,
  parameter int unsigned SLOT_LSB  = 8,
  parameter int unsigned IO_W      = 20,
  localparam int unsigned SLOT_W   = $clog2(SLOTS),
  localparam int unsigned REG_LSB  = 2,
  localparam int unsigned REG_W    = SLOT_LSB - REG_LSB
) (
  input  logic             hit_i,
  input  space_e           space_i,
  input  logic             we_i,
  input  logic [WIN_W-1:0] offset_i,
  output logic [3:0]       cbe_o,
  output logic [AD_W-1:0]  ad_o,
  output logic [SLOTS-1:0] idsel_o
);
  logic [SLOT_W-1:0] slot;
  logic [SLOTS-1:0]  slot_dec;
  logic              is_cfg;

  assign slot   = offset_i[SLOT_LSB +: SLOT_W];
  assign is_cfg = hit_i && (space_i == SP_CFG);

  for (genvar g = 0; g < SLOTS; g++) begin : g_idsel
    assign slot_dec[g] = (slot == SLOT_W'(g));
  end

  assign idsel_o = is_cfg ? slot_dec : '0;

  always_comb begin
    cbe_o = 4'b0000;
    if (hit_i) begin
      unique case (space_i)
        SP_LEGACY, SP_IO: cbe_o = {CMD_IO,  we_i};
        SP_CFG:           cbe_o = {CMD_CFG, we_i};
        SP_MEM:           cbe_o = {CMD_MEM, we_i};
        default:          cbe_o = 4'b0000;
      endcase
    end
  end

  always_comb begin
    ad_o = '0;
    if (hit_i) begin
      unique case (space_i)
        SP_LEGACY, SP_IO: ad_o[IO_W-1:0] = offset_i[IO_W-1:0];
        SP_CFG: begin
          ad_o[IDSEL_LSB +: SLOTS]  = slot_dec;
          ad_o[REG_LSB +: REG_W]    = offset_i[REG_LSB +: REG_W];
        end
        SP_MEM: begin
          ad_o[WIN_W-1:0] = offset_i;
          ad_o[1:0]       = 2'b00;
        end
        default: ad_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pci_space_decoder.sv
module pci_space_decoder
  import pci_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WIN_W   = 29,
  parameter int unsigned SLOTS   = 4,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned BASE_W = ADDR_W - WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] base_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic [1:0]        space_o,
  output logic [3:0]        cbe_o,
  output logic [ADDR_W-1:0] ad_o,
  output logic [SLOTS-1:0]  idsel_o
);
  logic              hit_c;
  logic [WIN_W-1:0]  offset_c;
  space_e            space_c;
  logic [3:0]        cbe_c;
  logic [ADDR_W-1:0] ad_c;
  logic [SLOTS-1:0]  idsel_c;
  logic [1:0]        space_q;

  pci_window_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_match (
    .addr_i(addr_i), .vld_i(addr_vld_i), .base_i(base_i),
    .hit_o(hit_c), .offset_o(offset_c)
  );

  pci_space_classify #(.WIN_W(WIN_W)) u_class (
    .offset_i(offset_c), .space_o(space_c)
  );

  pci_cmd_encode #(.WIN_W(WIN_W), .AD_W(ADDR_W), .SLOTS(SLOTS)) u_enc (
    .hit_i(hit_c), .space_i(space_c), .we_i(we_i), .offset_i(offset_c),
    .cbe_o(cbe_c), .ad_o(ad_c), .idsel_o(idsel_c)
  );

  assign space_q = hit_c ? space_c : 2'b00;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_o   <= 1'b0;
        space_o <= 2'b00;
        cbe_o   <= 4'b0000;
        ad_o    <= '0;
        idsel_o <= '0;
      end else begin
        hit_o   <= hit_c;
        space_o <= space_q;
        cbe_o   <= cbe_c;
        ad_o    <= ad_c;
        idsel_o <= idsel_c;
      end
    end

    p_miss_next_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!addr_vld_i || addr_i[ADDR_W-1:WIN_W] != base_i) |=> !hit_o);
  end else begin : g_comb
    assign hit_o   = hit_c;
    assign space_o = space_q;
    assign cbe_o   = cbe_c;
    assign ad_o    = ad_c;
    assign idsel_o = idsel_c;
  end

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (cbe_o == 4'b0 && ad_o == '0 && idsel_o == '0 && space_o == 2'b0));

  p_io_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o[1] == 1'b0) |-> (cbe_o[3:1] == 3'b001 && idsel_o == '0));

  p_mem_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o == 2'd3) |-> (cbe_o[3:1] == 3'b011 && ad_o[1:0] == 2'b00));

  p_cfg_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && space_o == 2'd2) |->
      ($countones(idsel_o) == 1 && ad_o[16 +: SLOTS] == idsel_o
       && ad_o[1:0] == 2'b00 && cbe_o[3:1] == 3'b101));

  p_sel_only_cfg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idsel_o != '0) |-> (hit_o && space_o == 2'd2));
endmodule

// File: tb/pci_space_decoder_tb.sv
module pci_space_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  base = '0;
  logic        vld = 1'b0;
  logic [31:0] addr = '0;
  logic        we = 1'b0;
  logic        hit;
  logic [1:0]  space;
  logic [3:0]  cbe;
  logic [31:0] ad;
  logic [3:0]  idsel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_space_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_i(base), .addr_vld_i(vld),
    .addr_i(addr), .we_i(we), .hit_o(hit), .space_o(space),
    .cbe_o(cbe), .ad_o(ad), .idsel_o(idsel)
  );

  typedef struct packed {
    logic        hit;
    logic [1:0]  space;
    logic [3:0]  cbe;
    logic [31:0] ad;
    logic [3:0]  idsel;
  } exp_t;

  function automatic exp_t model(input logic [2:0] b, input logic v,
                                 input logic [31:0] a, input logic w);
    exp_t e;
    logic [31:0] off;
    e = '0;
    off = {3'b000, a[28:0]};
    if (!(v && a[31:29] == b)) return e;
    e.hit = 1'b1;
    if (off < 32'h10000) begin
      e.space = 2'd0; e.cbe = {3'b001, w}; e.ad = off & 32'hFFFFF;
    end else if (off < 32'hF0000) begin
      e.space = 2'd1; e.cbe = {3'b001, w}; e.ad = off & 32'hFFFFF;
    end else if (off < 32'h100000) begin
      e.space = 2'd2; e.cbe = {3'b101, w};
      e.idsel = 4'b0001 << off[9:8];
      e.ad = (32'h1 << (16 + off[9:8])) | (off & 32'hFC);
    end else begin
      e.space = 2'd3; e.cbe = {3'b011, w}; e.ad = off & 32'hFFFF_FFFC;
    end
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (!e.hit) return "R1";
    case (e.space)
      2'd0, 2'd1: return "R4/R7";
      2'd2:       return "R5/R6";
      default:    return "R3/R8";
    endcase
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t got;
    got = '{hit, space, cbe, ad, idsel};
    n_chk++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h we=%b got hit=%b sp=%0d cbe=%b ad=%h sel=%b exp hit=%b sp=%0d cbe=%b ad=%h sel=%b",
               tag, addr, we, got.hit, got.space, got.cbe, got.ad, got.idsel,
               e.hit, e.space, e.cbe, e.ad, e.idsel);
    end
  endtask

  // drive at negedge, register at posedge, sample at following negedge
  task automatic apply(input logic [2:0] b, input logic v, input logic [31:0] a,
                       input logic w, input string tag);
    @(negedge clk);
    base = b; vld = v; addr = a; we = w;
    @(posedge clk);
    @(negedge clk);
    compare(model(b, v, a, w), (tag == "") ? tag_of(model(b, v, a, w)) : tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    // R9: reset state
    base = 3'd5; vld = 1'b1; addr = 32'hA000_0004; we = 1'b1;
    repeat (3) @(negedge clk);
    compare('0, "R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    vld = 1'b0;

    // R10 range edges, base 5 -> window 0xA0000000
    apply(3'd5, 1'b1, 32'hA000_FFFF, 1'b0, "R10 legacy edge");
    apply(3'd5, 1'b1, 32'hA001_0000, 1'b1, "R10 io low edge");
    apply(3'd5, 1'b1, 32'hA00E_FFFF, 1'b0, "R10 io high edge");
    apply(3'd5, 1'b1, 32'hA00F_0000, 1'b1, "R10 cfg low edge");
    apply(3'd5, 1'b1, 32'hA00F_FFFF, 1'b0, "R10 cfg high edge");
    apply(3'd5, 1'b1, 32'hA010_0000, 1'b1, "R10 mem low edge");
    apply(3'd5, 1'b1, 32'hBFFF_FFFF, 1'b0, "R10 mem high edge");
    apply(3'd5, 1'b1, 32'hA000_0003, 1'b1, "R7 legacy low bits");
    apply(3'd5, 1'b1, 32'hA123_4567, 1'b0, "R8 mem low bits cleared");

    // R6 slot sweep
    for (int s = 0; s < 4; s++) begin
      apply(3'd5, 1'b1, 32'hA00F_0000 | (s << 8) | (s * 12 + 4), s[0], "R6 slot sweep");
    end

    // R1 near misses and strobe low
    apply(3'd5, 1'b1, 32'h2000_0000, 1'b0, "R1 top bit differs");
    apply(3'd5, 1'b1, 32'h8010_0000, 1'b1, "R1 low base bit differs");
    apply(3'd5, 1'b1, 32'hE00F_0100, 1'b0, "R1 mid base bit differs");
    apply(3'd5, 1'b0, 32'hA00F_0100, 1'b0, "R1 strobe low");
    apply(3'd0, 1'b1, 32'h0000_0000, 1'b0, "R2 base zero");
    apply(3'd7, 1'b1, 32'hFFFF_FFFF, 1'b1, "R2 base seven");

    // R9 latency: new input must not show before the edge
    apply(3'd5, 1'b1, 32'hA010_0000, 1'b0, "R9 setup");
    @(negedge clk);
    addr = 32'hA000_0100; we = 1'b1;
    #1;
    compare(model(3'd5, 1'b1, 32'hA010_0000, 1'b0), "R9 latency");
    @(posedge clk);
    @(negedge clk);
    compare(model(3'd5, 1'b1, 32'hA000_0100, 1'b1), "R9 follow");

    // random mix, biased toward window and region edges
    for (int i = 0; i < 600; i++) begin
      logic [2:0]  b;
      logic [31:0] off;
      logic [31:0] a;
      b = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 4))
        0: off = $urandom_range(0, 32'hFFFF);
        1: off = $urandom_range(32'h10000, 32'hEFFFF);
        2: off = $urandom_range(32'hF0000, 32'hFFFFF);
        3: off = $urandom_range(32'h100000, 32'h1FFFFFFF);
        default: off = $urandom & 32'h1FFF_FFFF;
      endcase
      a = {($urandom_range(0, 3) == 0) ? 3'($urandom) : b, off[28:0]};
      apply(b, ($urandom_range(0, 7) != 0), a, 1'($urandom), "");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule